// File: doc/BRIEF.md
# PCI Configuration Cycle Address Generator

This block lives inside a PCI initiator. Software fills a configuration-address register (an enable flag plus bus, device, function and register numbers). It then reads or writes the configuration-data register. Each such access reaches this block as a one-cycle request with a read/write flag. The block sorts the access into one of four kinds: a type 0 configuration cycle on the local bus, a type 1 configuration cycle forwarded to a bus further down, an interrupt-acknowledge cycle, or a special cycle. It then produces the address phase on the bus: the address/data lines, the command/byte-enable lines, the active-low framing strobe and the address parity.

Configuration cycles get one extra address-stepping clock. The address and command are driven for a whole clock while the framing strobe is still high, so that an IDSEL input wired to an upper address line can settle. Interrupt-acknowledge and special cycles assert framing in the first driven clock. Once the address phase is over, the block raises a done flag towards the data-phase engine. It holds that flag, and refuses new requests, until the engine acknowledges.

Top module: `pci_cfg_addr_gen`

## Requirements
- R1: A type 1 cycle (enable set, bus number not zero) drives AD[31:2] with the register image {enable=1, seven zero bits, bus[7:0], device[4:0], function[2:0], register[5:0]} and drives AD[1:0] = 01.
- R2: A type 0 cycle (enable set, bus zero, not the all-ones pattern) drives AD[1:0] = 00, the function on AD[10:8], the register number on AD[7:2] and zeros on AD[15:11].
- R3: For type 0 and type 1 cycles, AD and C/BE are driven (output enable high) for one full clock with frame_n high. In the next clock frame_n is low and AD and C/BE are unchanged.
- R4: A read becomes interrupt-acknowledge only when enable=1, bus=0x00, device=11111, function=111 and register=000000. Any other local-bus field set (for example register=000001) gives a type 0 cycle instead.
- R5: On a type 0 cycle device n (0..15) sets only AD[16+n] among AD[31:16]. Devices 16..31 leave AD[31:16] all zero.
- R6: An interrupt-acknowledge cycle drives C/BE = 0000. AD carries the stable register image with AD[1:0] = 00 (0x8000FF00). frame_n goes low in the first driven clock, with no stepping clock.
- R7: With enable clear, an accepted request starts no bus activity: frame_n stays high, the output enables stay low and req_ready stays high.
- R8: A non-zero bus number gives a type 1 cycle even when device, function and register form the all-ones pattern.
- R9: Configuration reads use command 1010 and configuration writes use 1011.
- R10: A write with the interrupt-acknowledge field pattern issues a special cycle with command 0001, the same AD image as R6 and no stepping clock.
- R11: par_out is valid (par_oe high) for exactly the clock after the frame_n-low clock. It is set so that AD, C/BE and PAR together hold an even number of ones.
- R12: addr_done rises in the clock after the frame_n-low clock. It stays high, with req_ready low, until data_ack is sampled high. In the following clock addr_done is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Pending access to the configuration-data register |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_ready | output | 1 | Block is idle and accepts a request |
| cfg_enable | input | 1 | Enable flag of the configuration-address register |
| cfg_bus | input | 8 | Bus number field |
| cfg_dev | input | 5 | Device number field |
| cfg_func | input | 3 | Function number field |
| cfg_reg | input | 6 | Register number field |
| ad_out | output | 32 | Address driven on the AD lines |
| ad_oe | output | 1 | Output enable for AD |
| cbe_out | output | 4 | Command driven on C/BE |
| cbe_oe | output | 1 | Output enable for C/BE |
| frame_n | output | 1 | Active-low cycle framing strobe |
| par_out | output | 1 | Even parity over the previous clock's AD and C/BE |
| par_oe | output | 1 | Output enable for PAR |
| addr_done | output | 1 | Address phase finished, handed to the data-phase engine |
| data_ack | input | 1 | Data-phase engine has finished the cycle |

## Verification
A request is accepted on the rising edge where req_valid and req_ready are both high, and every result is counted from that edge. A configuration cycle drives AD and C/BE in the first clock after acceptance, pulls frame_n low in the second, and shows addr_done and PAR in the third. Interrupt-acknowledge and special cycles skip the stepping clock, so their results arrive one clock earlier. The bench drives on falling edges and samples each output at the falling edge inside the clock where that output is due. It sweeps every device number against several bus, function, register and direction values, so each classification and each IDSEL line is checked at its exact cycle.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  typedef enum logic [2:0] {
    KIND_NONE    = 3'd0,
    KIND_TYPE0   = 3'd1,
    KIND_TYPE1   = 3'd2,
    KIND_IACK    = 3'd3,
    KIND_SPECIAL = 3'd4
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_ADDR = 2'd2,
    ST_HAND = 2'd3
  } seq_state_e;

  localparam int unsigned CBE_W = 4;

  localparam logic [CBE_W-1:0] CMD_IACK    = 4'b0000;
  localparam logic [CBE_W-1:0] CMD_SPECIAL = 4'b0001;
  localparam logic [CBE_W-1:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [CBE_W-1:0] CMD_CFG_WR  = 4'b1011;

  // configuration kinds carry an address-stepping clock before framing
  function automatic logic kind_steps(cyc_kind_e k);
    return (k == KIND_TYPE0) || (k == KIND_TYPE1);
  endfunction

endpackage

// File: rtl/pci_cfg_rst_sync.sv
module pci_cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
  import pci_cfg_pkg::*;
#(
  parameter int unsigned AD_W       = 32,
  parameter int unsigned BUS_W      = 8,
  parameter int unsigned DEV_W      = 5,
  parameter int unsigned FUNC_W     = 3,
  parameter int unsigned REG_W      = 6,
  parameter int unsigned IDSEL_BASE = 16
) (
  input  logic              enable,
  input  logic              write,
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [REG_W-1:0]  regn,
  output cyc_kind_e         kind,
  output logic [AD_W-1:0]   ad,
  output logic [CBE_W-1:0]  cbe
);

  localparam int unsigned RSV_W     = AD_W - 1 - BUS_W - DEV_W - FUNC_W - REG_W - 2;
  localparam int unsigned NUM_IDSEL = AD_W - IDSEL_BASE;
  localparam int unsigned GAP_W     = IDSEL_BASE - FUNC_W - REG_W - 2;

  logic [NUM_IDSEL-1:0] idsel;
  logic [AD_W-1:0]      image;
  logic                 local_bus;
  logic                 ack_pattern;
  logic [CBE_W-1:0]     cfg_cmd;

  // one IDSEL line per low device number; higher numbers select nothing
  for (genvar n = 0; n < NUM_IDSEL; n++) begin : g_idsel
    assign idsel[n] = (dev == DEV_W'(n));
  end

  always_comb begin
    local_bus   = (bus == '0);
    ack_pattern = (dev == '1) && (func == '1) && (regn == '0);
    image       = {1'b1, {RSV_W{1'b0}}, bus, dev, func, regn, 2'b00};
    cfg_cmd     = write ? CMD_CFG_WR : CMD_CFG_RD;
  end

  always_comb begin
    kind = KIND_NONE;
    ad   = '0;
    cbe  = CMD_CFG_RD;
    if (!enable) begin
      kind = KIND_NONE;
    end else if (!local_bus) begin
      kind = KIND_TYPE1;
      ad   = {image[AD_W-1:2], 2'b01};
      cbe  = cfg_cmd;
    end else if (ack_pattern) begin
      kind = write ? KIND_SPECIAL : KIND_IACK;
      ad   = image;
      cbe  = write ? CMD_SPECIAL : CMD_IACK;
    end else begin
      kind = KIND_TYPE0;
      ad   = {idsel, {GAP_W{1'b0}}, func, regn, 2'b00};
      cbe  = cfg_cmd;
    end
  end

endmodule

// File: rtl/pci_cfg_seq.sv
module pci_cfg_seq
  import pci_cfg_pkg::*;
#(
  parameter int unsigned AD_W       = 32,
  parameter int unsigned IDSEL_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  cyc_kind_e        kind_in,
  input  logic [AD_W-1:0]  ad_in,
  input  logic [CBE_W-1:0] cbe_in,
  input  logic             data_ack,
  output logic [AD_W-1:0]  ad_out,
  output logic [CBE_W-1:0] cbe_out,
  output logic             bus_oe,
  output logic             frame_n,
  output logic             addr_phase,
  output logic             addr_done
);

  seq_state_e       state_q, state_d;
  cyc_kind_e        kind_q;
  logic [AD_W-1:0]  ad_q;
  logic [CBE_W-1:0] cbe_q;
  logic             accept;
  logic             load;

  always_comb begin
    accept = req_valid && (state_q == ST_IDLE);
    load   = accept && (kind_in != KIND_NONE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load) state_d = kind_steps(kind_in) ? ST_STEP : ST_ADDR;
      ST_STEP: state_d = ST_ADDR;
      ST_ADDR: state_d = ST_HAND;
      ST_HAND: if (data_ack) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // address image captured once per accepted cycle, held through the phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_NONE;
      ad_q   <= '0;
      cbe_q  <= '0;
    end else if (load) begin
      kind_q <= kind_in;
      ad_q   <= ad_in;
      cbe_q  <= cbe_in;
    end
  end

  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    bus_oe     = (state_q == ST_STEP) || (state_q == ST_ADDR);
    frame_n    = (state_q != ST_ADDR);
    addr_phase = (state_q == ST_ADDR);
    addr_done  = (state_q == ST_HAND);
    ad_out     = ad_q;
    cbe_out    = cbe_q;
  end

  AST_STEP_BEFORE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && kind_steps(kind_q)) |-> ($past(state_q) == ST_STEP)); // R3

  AST_STEP_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && kind_steps(kind_q)) |-> ($stable(ad_q) && $stable(cbe_q))); // R3

  AST_TYPE1_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && kind_q == KIND_TYPE1) |-> (ad_out[1:0] == 2'b01)); // R1

  AST_TYPE0_IDSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && kind_q == KIND_TYPE0) |-> ($onehot0(ad_out[AD_W-1:IDSEL_BASE]) && ad_out[1:0] == 2'b00)); // R5

  AST_IACK_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && kind_q == KIND_IACK) |-> (cbe_out == CMD_IACK)); // R6

  AST_DISABLED_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind_in == KIND_NONE) |=> (state_q == ST_IDLE)); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !data_ack) |=> (addr_done && !req_ready)); // R12

endmodule

// File: rtl/pci_cfg_parity.sv
module pci_cfg_parity
  import pci_cfg_pkg::*;
#(
  parameter int unsigned AD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe,
  output logic             par,
  output logic             par_oe
);

  logic par_q, par_d;
  logic oe_q;

  always_comb begin
    par_d = addr_phase ? ^{ad, cbe} : par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_d;
      oe_q  <= addr_phase;
    end
  end

  assign par    = par_q;
  assign par_oe = oe_q;

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ((^{$past(ad), $past(cbe), par}) == 1'b0)); // R11

  AST_PAR_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> par_oe); // R11

endmodule

// File: rtl/pci_cfg_addr_gen.sv
module pci_cfg_addr_gen
  import pci_cfg_pkg::*;
#(
  parameter int unsigned AD_W       = 32,
  parameter int unsigned BUS_W      = 8,
  parameter int unsigned DEV_W      = 5,
  parameter int unsigned FUNC_W     = 3,
  parameter int unsigned REG_W      = 6,
  parameter int unsigned IDSEL_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  input  logic              cfg_enable,
  input  logic [BUS_W-1:0]  cfg_bus,
  input  logic [DEV_W-1:0]  cfg_dev,
  input  logic [FUNC_W-1:0] cfg_func,
  input  logic [REG_W-1:0]  cfg_reg,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic [3:0]        cbe_out,
  output logic              cbe_oe,
  output logic              frame_n,
  output logic              par_out,
  output logic              par_oe,
  output logic              addr_done,
  input  logic              data_ack
);

  logic             rst_sync_n;
  cyc_kind_e        dec_kind;
  logic [AD_W-1:0]  dec_ad;
  logic [CBE_W-1:0] dec_cbe;
  logic             bus_oe;
  logic             addr_phase;

  pci_cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pci_cfg_decode #(
    .AD_W(AD_W), .BUS_W(BUS_W), .DEV_W(DEV_W),
    .FUNC_W(FUNC_W), .REG_W(REG_W), .IDSEL_BASE(IDSEL_BASE)
  ) u_dec (
    .enable (cfg_enable),
    .write  (req_write),
    .bus    (cfg_bus),
    .dev    (cfg_dev),
    .func   (cfg_func),
    .regn   (cfg_reg),
    .kind   (dec_kind),
    .ad     (dec_ad),
    .cbe    (dec_cbe)
  );

  pci_cfg_seq #(.AD_W(AD_W), .IDSEL_BASE(IDSEL_BASE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .kind_in    (dec_kind),
    .ad_in      (dec_ad),
    .cbe_in     (dec_cbe),
    .data_ack   (data_ack),
    .ad_out     (ad_out),
    .cbe_out    (cbe_out),
    .bus_oe     (bus_oe),
    .frame_n    (frame_n),
    .addr_phase (addr_phase),
    .addr_done  (addr_done)
  );

  pci_cfg_parity #(.AD_W(AD_W)) u_par (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_phase (addr_phase),
    .ad         (ad_out),
    .cbe        (cbe_out),
    .par        (par_out),
    .par_oe     (par_oe)
  );

  assign ad_oe  = bus_oe;
  assign cbe_oe = bus_oe;

endmodule

// File: tb/pci_cfg_addr_gen_tb_top.sv
module pci_cfg_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_ready;
  logic        cfg_enable = 1'b0;
  logic [7:0]  cfg_bus = '0;
  logic [4:0]  cfg_dev = '0;
  logic [2:0]  cfg_func = '0;
  logic [5:0]  cfg_reg = '0;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [3:0]  cbe_out;
  logic        cbe_oe;
  logic        frame_n;
  logic        par_out;
  logic        par_oe;
  logic        addr_done;
  logic        data_ack = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pci_cfg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .cfg_enable(cfg_enable), .cfg_bus(cfg_bus),
    .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_reg(cfg_reg),
    .ad_out(ad_out), .ad_oe(ad_oe), .cbe_out(cbe_out), .cbe_oe(cbe_oe),
    .frame_n(frame_n), .par_out(par_out), .par_oe(par_oe),
    .addr_done(addr_done), .data_ack(data_ack)
  );

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // kinds: 0 none, 1 type0, 2 type1, 3 iack, 4 special
  task automatic run(bit wr, bit en, bit [7:0] bus, bit [4:0] dev, bit [2:0] fn, bit [5:0] rg);
    int          ek;
    logic [31:0] ead;
    logic [3:0]  ecbe;
    logic [31:0] img;
    bit          pat;
    string       adtag, cbetag;
    pat = (dev == 5'd31) && (fn == 3'd7) && (rg == 6'd0);
    img = 32'h8000_0000 | ({24'd0, bus} << 16) | ({27'd0, dev} << 11)
        | ({29'd0, fn} << 8) | ({26'd0, rg} << 2);
    if (!en) begin
      ek = 0; ead = '0; ecbe = '0; adtag = "R7"; cbetag = "R7";
    end else if (bus != 0) begin
      ek = 2; ead = img | 32'd1; ecbe = wr ? 4'b1011 : 4'b1010;
      adtag = pat ? "R8" : "R1"; cbetag = "R9";
    end else if (pat) begin
      ek = wr ? 4 : 3; ead = img; ecbe = wr ? 4'b0001 : 4'b0000;
      adtag = wr ? "R10" : "R6"; cbetag = wr ? "R10" : "R4";
    end else begin
      ek = 1;
      ead = ((dev < 16) ? (32'd1 << (16 + dev)) : 32'd0)
          | ({29'd0, fn} << 8) | ({26'd0, rg} << 2);
      ecbe = wr ? 4'b1011 : 4'b1010;
      adtag = "R2 R5"; cbetag = "R9";
    end

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; cfg_enable = en;
    cfg_bus = bus; cfg_dev = dev; cfg_func = fn; cfg_reg = rg;
    @(negedge clk);
    req_valid = 1'b0;

    if (ek == 0) begin
      chk("R7 frame", {35'd0, frame_n}, 36'd1);
      chk("R7 oe", {34'd0, ad_oe, cbe_oe}, 36'd0);
      chk("R7 ready", {35'd0, req_ready}, 36'd1);
      return;
    end

    if (ek == 1 || ek == 2) begin
      chk("R3 step frame", {35'd0, frame_n}, 36'd1);
      chk("R3 step oe", {34'd0, ad_oe, cbe_oe}, 36'd3);
      chk(adtag, {4'd0, ad_out}, {4'd0, ead});
      chk(cbetag, {32'd0, cbe_out}, {32'd0, ecbe});
      @(negedge clk);
      chk("R3 frame low", {35'd0, frame_n}, 36'd0);
    end else begin
      chk("R6 no step frame", {35'd0, frame_n}, 36'd0);
    end
    chk(adtag, {4'd0, ad_out}, {4'd0, ead});
    chk(cbetag, {32'd0, cbe_out}, {32'd0, ecbe});
    chk("R3 oe in addr", {34'd0, ad_oe, cbe_oe}, 36'd3);

    @(negedge clk);
    chk("R12 done", {34'd0, addr_done, req_ready}, 36'd2);
    chk("R11 par", {34'd0, par_oe, par_out}, {34'd0, 1'b1, ^{ead, ecbe}});
    chk("R12 frame released", {35'd0, frame_n}, 36'd1);

    @(negedge clk);
    chk("R12 hold", {34'd0, addr_done, req_ready}, 36'd2);
    chk("R11 par one clock", {35'd0, par_oe}, 36'd0);

    data_ack = 1'b1;
    @(negedge clk);
    data_ack = 1'b0;
    chk("R12 release", {34'd0, addr_done, req_ready}, 36'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("reset state", {31'd0, req_ready, frame_n, ad_oe, addr_done, par_oe}, 36'b11000);

    // near-exhaustive sweep of device numbers against bus, function, register and direction
    for (int b = 0; b < 3; b++) begin
      for (int d = 0; d < 32; d++) begin
        for (int f = 0; f < 3; f++) begin
          for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < 2; w++) begin
              bit [7:0] bv;
              bit [2:0] fv;
              bit [5:0] rv;
              bv = (b == 0) ? 8'h00 : ((b == 1) ? 8'h01 : 8'hA5);
              fv = (f == 0) ? 3'd0 : ((f == 1) ? 3'd7 : 3'd3);
              rv = (r == 0) ? 6'd0 : 6'(d * 2 + 1);
              run(w[0], 1'b1, bv, d[4:0], fv, rv);
            end
          end
        end
      end
    end

    // R4: one field away from the interrupt-acknowledge pattern
    run(1'b0, 1'b1, 8'h00, 5'd31, 3'd7, 6'd1);
    run(1'b0, 1'b1, 8'h00, 5'd30, 3'd7, 6'd0);
    run(1'b0, 1'b1, 8'h00, 5'd31, 3'd6, 6'd0);
    // R8: all-ones pattern behind a bridge
    run(1'b0, 1'b1, 8'hFF, 5'd31, 3'd7, 6'd0);
    run(1'b1, 1'b1, 8'h80, 5'd31, 3'd7, 6'd0);
    // R7: enable clear, including the acknowledge pattern
    run(1'b0, 1'b0, 8'h00, 5'd31, 3'd7, 6'd0);
    run(1'b1, 1'b0, 8'h00, 5'd31, 3'd7, 6'd0);
    run(1'b0, 1'b0, 8'h12, 5'd3, 3'd1, 6'd4);
    run(1'b1, 1'b0, 8'h00, 5'd0, 3'd0, 6'd0);
    // R7 followed by a real cycle proves the block stayed idle
    run(1'b0, 1'b1, 8'h00, 5'd5, 3'd2, 6'd9);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule